// File: doc/BRIEF.md
# Serial-loaded synthesizer and mixer control register bank

This block receives 24-bit configuration words over a three-wire serial write port (serial clock, serial data, load strobe) and stores them in a bank of eight control registers. The word is shifted in most significant bit first. When the load strobe rises, the word goes into the register whose address sits in the word's three least significant bits. The registers set up a fractional-N frequency synthesizer and a downconverting mixer. The bank brings out all eight registers and also presents the synthesizer's integer, modulus and fraction values and its charge-pump current setting in decoded form.

When a word lands in one of the three frequency registers (integer, modulus, fraction), the bank raises a single-cycle calibration-start pulse for the synthesizer's calibration engine. It also works out where the mixer's local oscillator comes from. It combines two external pins (synthesizer enable, LO driver enable) with two bits of register 5. From these it decides whether the LO is generated internally and whether the LO output buffer is driven.

The serial pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer and an edge detector. The system clock must therefore run at least four times faster than the serial clock.

Top module: `serial_cfg_bank`

## Requirements
- R1: After reset the registers hold reg0=0x0001C0, reg1=0x003001, reg2=0x000002, reg3=0x000003, reg4=0x000404, reg5=0x000045, reg6=0x1E2106 and reg7=0x000007. Register i appears on cfg_flat[24*i+23:24*i].
- R2: Each rising serial clock shifts one data bit into a 24-bit word, most significant bit first. A rising load strobe copies the whole word into the register addressed by word bits [2:0]. The other registers keep their values.
- R3: When more than 24 serial clocks arrive before the load strobe, only the last 24 bits shifted in are kept.
- R4: cal_start is high for exactly one system clock after each load into register 0, 1 or 2. It is high no earlier than the cycle in which the new value appears on cfg_flat. Loads into registers 3 to 7 never raise it.
- R5: int_div is reg0 bits [9:3], mod_div is reg1 bits [13:3] and frac_div is reg2 bits [13:3].
- R6: reg4 bits [11:10] hold a code c, and cp_ua equals 250*(c+1) microamps. cp_ext_ref equals reg4 bit 18, where 0 selects the internal reference and 1 the external one.
- R7: lo_internal is 0 and lo_buf_en is 0 whenever pll_en_pin is 0 or reg5 bit 6 (synthesizer enable) is 0.
- R8: When pll_en_pin and reg5 bit 6 are both 1, lo_internal is 1. In that case lo_buf_en is 1 exactly when lo_drv_pin is 1 or reg5 bit 3 (LO driver enable) is 1.
- R9: Serial clocking without a rising load strobe changes no register and raises no cal_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, sampled on ser_clk rise |
| ser_le | input | 1 | Load strobe, rising edge commits the word |
| pll_en_pin | input | 1 | External synthesizer enable pin |
| lo_drv_pin | input | 1 | External LO output driver enable pin |
| cfg_flat | output | 192 | All eight registers, register i at bits 24*i+23:24*i |
| cal_start | output | 1 | One-cycle calibration start pulse |
| int_div | output | 7 | Decoded integer divide value |
| mod_div | output | 11 | Decoded modulus |
| frac_div | output | 11 | Decoded fraction |
| cp_ua | output | 10 | Charge-pump current in microamps |
| cp_ext_ref | output | 1 | Charge-pump external reference selected |
| lo_internal | output | 1 | LO generated by the internal synthesizer |
| lo_buf_en | output | 1 | LO output buffer enabled |

## Verification
The hardest state to reach from the ports is a shift word that holds more than 24 bits of history at the moment the strobe rises. Only a run of extra serial clocks before the strobe produces it. The stimulus sends six junk bits ahead of a full word and checks that the junk is gone. Another hard-to-reach state is a full 24-bit word sitting in the shifter without being committed. The stimulus shifts a complete word with the strobe held low, confirms that nothing changed, and then overwrites that word with a real load. The LO selection is swept over all sixteen pin and bit combinations, each set up by rewriting register 5.

// File: rtl/cfgbank_pkg.sv
// Shared constants and reset values for the serial configuration bank.
package cfgbank_pkg;
    localparam int WORD_W   = 24;
    localparam int NUM_REGS = 8;
    localparam int ADDR_W   = $clog2(NUM_REGS);
    localparam int CAL_REGS = 3;   // registers 0..CAL_REGS-1 trigger calibration

    // Field positions that the decoders depend on
    localparam int INT_LSB  = 3;
    localparam int INT_W    = 7;
    localparam int MOD_LSB  = 3;
    localparam int MOD_W    = 11;
    localparam int CP_LSB   = 10;
    localparam int CPREF_B  = 18;
    localparam int SYNEN_B  = 6;
    localparam int DRVEN_B  = 3;

    // Reset value of register idx
    function automatic logic [WORD_W-1:0] reset_word(input int idx);
        case (idx)
            0:       return 24'h0001C0;
            1:       return 24'h003001;
            4:       return 24'h000404;
            5:       return 24'h000045;
            6:       return 24'h1E2106;
            default: return WORD_W'(idx);
        endcase
    endfunction
endpackage

// File: rtl/cfgb_sync.sv
// Multi-bit level synchronizer: each bit passes through STAGES flops.
// Assumes inputs are independent asynchronous levels; no bus coherency.
module cfgb_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the asynchronous levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/cfgb_shifter.sv
// Serial-in word shifter, MSB first; keeps only the newest W bits.
// Assumes shift_en is a single-cycle strobe in the system clock domain.
module cfgb_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    // Append one bit at the LSB end on every strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[W-2:0], bit_in};
    end
endmodule

// File: rtl/cfgb_regfile.sv
// Bank of N control registers written from a whole word whose low bits
// carry the address; raises a one-cycle calibration pulse on writes to
// the first CAL_REGS registers. Assumes load is a single-cycle strobe.
module cfgb_regfile
    import cfgbank_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int N    = NUM_REGS,
    parameter int NCAL = CAL_REGS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [W-1:0]   word_in,
    output logic [N*W-1:0] regs_flat,
    output logic           cal_start
);
    localparam int AW = $clog2(N);
    logic [AW-1:0] addr;
    assign addr = word_in[AW-1:0];

    for (genvar i = 0; i < N; i++) begin : g_reg
        logic [W-1:0] q;
        // Hold register i, load it when the word addresses it
        always_ff @(posedge clk) begin
            if (!rst_n)                          q <= W'(reset_word(i));
            else if (load && addr == AW'(i))     q <= word_in;
        end
        assign regs_flat[i*W +: W] = q;
    end

    // Pulse calibration in step with the register update
    always_ff @(posedge clk) begin
        if (!rst_n) cal_start <= 1'b0;
        else        cal_start <= load && (int'(addr) < NCAL);
    end
endmodule

// File: rtl/cfgb_lo_select.sv
// Resolves LO source and LO buffer enable from pins and register bits.
// Pins are treated as static straps; purely combinational.
module cfgb_lo_select (
    input  logic pll_en_pin,
    input  logic lo_drv_pin,
    input  logic syn_en_bit,
    input  logic drv_en_bit,
    output logic lo_internal,
    output logic lo_buf_en
);
    // Internal LO needs both enables; buffer needs either driver request
    always_comb begin
        lo_internal = pll_en_pin & syn_en_bit;
        lo_buf_en   = lo_internal & (lo_drv_pin | drv_en_bit);
    end
endmodule

// File: rtl/serial_cfg_bank.sv
// Top: three-wire serial write port feeding eight 24-bit control
// registers, with synthesizer field decode, calibration start pulse and
// LO path selection. Assumes clk is at least 4x the serial clock rate.
module serial_cfg_bank
    import cfgbank_pkg::*;
#(
    parameter int W           = WORD_W,
    parameter int N           = NUM_REGS,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_le,
    input  logic           pll_en_pin,
    input  logic           lo_drv_pin,
    output logic [N*W-1:0] cfg_flat,
    output logic           cal_start,
    output logic [INT_W-1:0] int_div,
    output logic [MOD_W-1:0] mod_div,
    output logic [MOD_W-1:0] frac_div,
    output logic [9:0]     cp_ua,
    output logic           cp_ext_ref,
    output logic           lo_internal,
    output logic           lo_buf_en
);
    logic [2:0]   pins_s;
    logic         clk_q, le_q;
    logic         clk_rise, le_rise;
    logic [W-1:0] word;
    logic [W-1:0] reg0, reg1, reg2, reg4, reg5;
    logic [1:0]   cp_code;

    cfgb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({ser_le, ser_data, ser_clk}),
        .sync_out(pins_s)
    );

    // Remember previous synchronized clock and strobe for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
            le_q  <= 1'b0;
        end else begin
            clk_q <= pins_s[0];
            le_q  <= pins_s[2];
        end
    end

    assign clk_rise = pins_s[0] & ~clk_q;
    assign le_rise  = pins_s[2] & ~le_q;

    cfgb_shifter #(.W(W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(clk_rise),
        .bit_in(pins_s[1]), .word(word)
    );

    cfgb_regfile #(.W(W), .N(N), .NCAL(CAL_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .load(le_rise), .word_in(word),
        .regs_flat(cfg_flat), .cal_start(cal_start)
    );

    assign reg0 = cfg_flat[0*W +: W];
    assign reg1 = cfg_flat[1*W +: W];
    assign reg2 = cfg_flat[2*W +: W];
    assign reg4 = cfg_flat[4*W +: W];
    assign reg5 = cfg_flat[5*W +: W];

    // Decode synthesizer fields and charge-pump setting
    always_comb begin
        int_div    = reg0[INT_LSB +: INT_W];
        mod_div    = reg1[MOD_LSB +: MOD_W];
        frac_div   = reg2[MOD_LSB +: MOD_W];
        cp_code    = reg4[CP_LSB +: 2];
        cp_ua      = 10'd250 * (10'(cp_code) + 10'd1);
        cp_ext_ref = reg4[CPREF_B];
    end

    cfgb_lo_select u_lo (
        .pll_en_pin(pll_en_pin), .lo_drv_pin(lo_drv_pin),
        .syn_en_bit(reg5[SYNEN_B]), .drv_en_bit(reg5[DRVEN_B]),
        .lo_internal(lo_internal), .lo_buf_en(lo_buf_en)
    );
endmodule

// File: rtl/serial_cfg_bank_chk.sv
// Property checker for serial_cfg_bank, attached by bind.
module serial_cfg_bank_chk #(
    parameter int FW = 192
) (
    input logic          clk,
    input logic          rst_n,
    input logic          le_rise,
    input logic          cal_start,
    input logic [FW-1:0] cfg_flat,
    input logic [9:0]    cp_ua,
    input logic          pll_en_pin,
    input logic          lo_internal,
    input logic          lo_buf_en
);
    AST_CAL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);                                    // R4
    AST_CAL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> $past(le_rise));                                // R4
    AST_NO_LOAD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable(cfg_flat));                              // R9
    AST_CP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cp_ua == 10'd250 || cp_ua == 10'd500 || cp_ua == 10'd750 || cp_ua == 10'd1000); // R6
    AST_PIN_LOW_EXTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en_pin |-> (!lo_internal && !lo_buf_en));                // R7
    AST_BUF_NEEDS_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        lo_buf_en |-> lo_internal);                                   // R8
endmodule

bind serial_cfg_bank serial_cfg_bank_chk #(.FW(N*W)) u_chk (
    .clk(clk), .rst_n(rst_n), .le_rise(le_rise), .cal_start(cal_start),
    .cfg_flat(cfg_flat), .cp_ua(cp_ua), .pll_en_pin(pll_en_pin),
    .lo_internal(lo_internal), .lo_buf_en(lo_buf_en)
);

// File: tb/serial_cfg_bank_tb.sv
module serial_cfg_bank_tb;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic pll_en_pin = 1'b1, lo_drv_pin = 1'b0;
    logic [191:0] cfg_flat;
    logic cal_start, cp_ext_ref, lo_internal, lo_buf_en;
    logic [6:0] int_div;
    logic [10:0] mod_div, frac_div;
    logic [9:0] cp_ua;

    int checks = 0, errors = 0, cal_cnt = 0;
    bit done = 0;
    logic [23:0] model [8];

    typedef struct {
        logic [191:0] flat;
        int           cal;
        string        tag;
    } item_t;
    item_t exp_q [$];

    always #10 clk = ~clk;   // 50 MHz

    serial_cfg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .pll_en_pin(pll_en_pin), .lo_drv_pin(lo_drv_pin),
        .cfg_flat(cfg_flat), .cal_start(cal_start), .int_div(int_div),
        .mod_div(mod_div), .frac_div(frac_div), .cp_ua(cp_ua),
        .cp_ext_ref(cp_ext_ref), .lo_internal(lo_internal), .lo_buf_en(lo_buf_en)
    );

    function automatic logic [191:0] model_flat();
        logic [191:0] f;
        for (int i = 0; i < 8; i++) f[i*24 +: 24] = model[i];
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Count calibration pulses away from the active edge
    always @(negedge clk) if (rst_n && cal_start) cal_cnt++;

    // Monitor: pop expected items and compare with the outputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (cfg_flat !== it.flat) begin
                errors++;
                $display("FAIL %s regs actual=%h expected=%h", it.tag, cfg_flat, it.flat);
            end
            check(cal_cnt == it.cal, {it.tag, " cal count"}, cal_cnt, it.cal);
        end
    end

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int b = n - 1; b >= 0; b--) begin
            @(negedge clk); ser_data = v[b];
            repeat (2) @(negedge clk); ser_clk = 1'b1;
            repeat (4) @(negedge clk); ser_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic pulse_le();
        @(negedge clk); ser_le = 1'b1;
        repeat (4) @(negedge clk); ser_le = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Driver: write a word, update model, push the expected item
    task automatic write_word(input logic [23:0] w, input string tag, input int extra_cal);
        static int exp_cal = 0;
        send_bits(64'(w), 24);
        pulse_le();
        model[w[2:0]] = w;
        exp_cal = cal_cnt_base + extra_cal;
        cal_cnt_base = exp_cal;
        @(posedge clk);
        exp_q.push_back('{model_flat(), exp_cal, tag});
        repeat (2) @(negedge clk);
    endtask
    int cal_cnt_base = 0;

    initial begin
        model[0] = 24'h0001C0; model[1] = 24'h003001; model[2] = 24'h000002;
        model[3] = 24'h000003; model[4] = 24'h000404; model[5] = 24'h000045;
        model[6] = 24'h1E2106; model[7] = 24'h000007;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);

        // R1 reset defaults and decoded reset fields (R5, R6)
        check(cfg_flat === model_flat(), "R1 reset regs", cfg_flat[63:0], model_flat() & 64'hFFFFFFFFFFFFFFFF);
        check(int_div == 7'd56, "R5 reset int", int_div, 56);
        check(mod_div == 11'd1536, "R5 reset mod", mod_div, 1536);
        check(cp_ua == 10'd500 && !cp_ext_ref, "R6 reset cp", cp_ua, 500);
        check(lo_internal && !lo_buf_en, "R8 reset lo", {lo_internal, lo_buf_en}, 2);

        // R2, R4, R5: frequency registers
        write_word(24'h000320, "R2 R4 reg0", 1);
        check(int_div == 7'd100, "R5 int", int_div, 100);
        write_word(24'h003FF9, "R2 R4 reg1", 1);
        check(mod_div == 11'd2047, "R5 mod", mod_div, 2047);
        write_word(24'h002692, "R2 R4 reg2", 1);
        check(frac_div == 11'd1234, "R5 frac", frac_div, 1234);

        // R4: non-frequency registers raise no calibration
        write_word(24'hABCDE3, "R4 reg3 nocal", 0);
        write_word(24'h123457, "R4 reg7 nocal", 0);

        // R6: charge-pump code and reference
        write_word(24'h040C04, "R6 reg4 max", 0);
        check(cp_ua == 10'd1000 && cp_ext_ref, "R6 cp 1000 ext", cp_ua, 1000);
        write_word(24'h000004, "R6 reg4 min", 0);
        check(cp_ua == 10'd250 && !cp_ext_ref, "R6 cp 250 int", cp_ua, 250);
        write_word(24'h000804, "R6 reg4 code2", 0);
        check(cp_ua == 10'd750, "R6 cp 750", cp_ua, 750);

        // R3: extra clocks before the strobe, only last 24 bits kept
        send_bits(64'h2D, 6);
        write_word(24'h5A5A5E, "R3 overshift reg6", 0);

        // R9: a full word shifted without the strobe changes nothing
        send_bits(64'hFFFFF8, 24);
        repeat (10) @(negedge clk);
        @(posedge clk);
        exp_q.push_back('{model_flat(), cal_cnt_base, "R9 no strobe"});
        repeat (4) @(negedge clk);

        // R7, R8: sweep pins and register 5 bits
        for (int k = 0; k < 4; k++) begin
            logic [23:0] w5;
            w5 = 24'h5 | (24'(k[1]) << 6) | (24'(k[0]) << 3);
            write_word(w5, "R7 R8 reg5", 0);
            for (int p = 0; p < 4; p++) begin
                bit e_int, e_buf;
                @(negedge clk); pll_en_pin = p[1]; lo_drv_pin = p[0];
                @(negedge clk);
                e_int = p[1] & k[1];
                e_buf = e_int & (p[0] | k[0]);
                check(lo_internal == e_int && lo_buf_en == e_buf,
                      e_int ? "R8 lo select" : "R7 lo select",
                      {lo_internal, lo_buf_en}, {e_int, e_buf});
            end
            pll_en_pin = 1'b1; lo_drv_pin = 1'b0;
        end

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule